// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns an active-low interrupt pin into a request for a small 8-bit CPU core. The pin is first brought into the core clock domain. It is then judged in one of two ways: either a held low level counts as a request, or a falling transition is captured in a pending flag. A control byte in the CPU's register space selects the mode and turns the source on or off. The request reaches the CPU only while the CPU's global interrupt mask is clear.

When the CPU starts vectoring, it pulses an acknowledge. The acknowledge clears the pending flag. A new falling edge that arrives during the service routine is therefore kept, and it is taken once the mask is released. Wired-OR sources work in level mode, because a line that stays low keeps asking. The block also returns the address of the vector byte that the CPU is fetching.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, a read of the control byte at address 0x0C returns 0x10. This means enabled, level mode. A read of any other address returns 0x00.
- R2: A write to address 0x0C stores all eight bits, which read back unchanged. A write to any other address leaves the control byte unchanged.
- R3: While control bit 4 (enable) is 0, the request stays low and the pending edge flag is cleared.
- R4: With bit 4 = 1 and bit 5 (option) = 0, the trigger is the low level. The request rises on the second rising clock edge after the pin goes low. It falls on the second rising clock edge after the pin returns high.
- R5: With bit 4 = 1 and bit 5 = 1, a falling pin edge sets the pending flag. The request rises on the third rising clock edge after the pin falls, and it stays high after the pin returns high.
- R6: While the mask input is 1, the request is low. A pending edge or a held low level raises the request in the same cycle that the mask returns to 0.
- R7: An acknowledge pulse clears the pending flag. A falling edge that is detected in the same cycle as the acknowledge wins, and the flag stays set.
- R8: One falling edge that arrives after acknowledge, while the mask is 1, is remembered. It raises the request once the mask clears, and a second acknowledge removes it.
- R9: The vector address output is 0x1FFA when the byte select is 0 (high byte) and 0x1FFB when it is 1 (low byte).
- R10: In level mode, an acknowledge has no effect. While the pin stays low, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| cpu_mask | input | 1 | CPU global interrupt mask bit |
| irq_ack | input | 1 | One-cycle pulse when the CPU begins vectoring |
| reg_addr | input | 8 | Register port address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| vec_byte | input | 1 | Vector byte select: 0 high, 1 low |
| vec_addr | output | 16 | Address of the selected vector byte |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: an 8-bit register address, a two-stage synchronizer, the control byte at 0x0C and the vector base at 0x1FFA. The address space is small, so the bench sweeps all 256 addresses for read and write decode. It also walks every combination of enable, option and mask through a pin low/high cycle and an acknowledge. The fixed synchronizer depth lets the bench check the exact cycle of the level and edge latencies. It also lets the bench place a falling edge in the same cycle as an acknowledge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    parameter int DATA_W  = 8;
    parameter int EN_POS  = 4;
    parameter int OPT_POS = 5;
    parameter int VEC_W   = 16;

    typedef struct packed {
        logic enable;
        logic on_edge;
    } trig_cfg_t;

    typedef enum logic {
        VEC_HI = 1'b0,
        VEC_LO = 1'b1
    } vec_byte_e;

    function automatic trig_cfg_t decode_cfg(input logic [DATA_W-1:0] c);
        trig_cfg_t t;
        t.enable  = c[EN_POS];
        t.on_edge = c[OPT_POS];
        return t;
    endfunction

    function automatic logic [VEC_W-1:0] vector_of(input logic [VEC_W-1:0] base,
                                                   input vec_byte_e sel);
        return (sel == VEC_LO) ? base + VEC_W'(1) : base;
    endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{1'b1}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xirq_ctlreg.sv
module xirq_ctlreg
    import xirq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0C,
    parameter logic [DATA_W-1:0] RST_VAL  = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctl_q
);
    logic hit;
    assign hit = (addr == CTL_ADDR);

    always_ff @(posedge clk) begin
        if (rst)            ctl_q <= RST_VAL;
        else if (we && hit) ctl_q <= wdata;
    end

    assign rdata = hit ? ctl_q : '0;
endmodule

// File: rtl/xirq_trigger.sv
module xirq_trigger
    import xirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_s,
    input  trig_cfg_t cfg,
    input  logic      mask,
    input  logic      ack,
    output logic      fall_seen,
    output logic      edge_pend,
    output logic      req
);
    logic prev_q;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= pin_s;
    end

    assign fall_seen = prev_q & ~pin_s;
    assign armed     = cfg.enable & cfg.on_edge;

    always_ff @(posedge clk) begin
        if (rst)            edge_pend <= 1'b0;
        else if (!armed)    edge_pend <= 1'b0;
        else if (fall_seen) edge_pend <= 1'b1;
        else if (ack)       edge_pend <= 1'b0;
    end

    always_comb begin
        if (!cfg.enable || mask) req = 1'b0;
        else if (cfg.on_edge)    req = edge_pend;
        else                     req = ~pin_s;
    end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR    = 8'h0C,
    parameter logic [DATA_W-1:0] CTL_RST     = 8'h10,
    parameter int                SYNC_STAGES = 2,
    parameter logic [VEC_W-1:0]  VEC_BASE    = 16'h1FFA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin_n,
    input  logic              cpu_mask,
    input  logic              irq_ack,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              vec_byte,
    output logic [VEC_W-1:0]  vec_addr,
    output logic              irq_req
);
    logic [DATA_W-1:0] ctl_q;
    trig_cfg_t         cfg;
    logic              pin_s;
    logic              fall_seen;
    logic              edge_pend;

    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(irq_pin_n), .q(pin_s)
    );

    xirq_ctlreg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .RST_VAL(CTL_RST)) u_reg (
        .clk(clk), .rst(rst), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctl_q(ctl_q)
    );

    assign cfg = decode_cfg(ctl_q);

    xirq_trigger u_trig (
        .clk(clk), .rst(rst), .pin_s(pin_s), .cfg(cfg), .mask(cpu_mask),
        .ack(irq_ack), .fall_seen(fall_seen), .edge_pend(edge_pend), .req(irq_req)
    );

    assign vec_addr = vector_of(VEC_BASE, vec_byte_e'(vec_byte));
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
    import xirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_mask,
    input logic              irq_ack,
    input logic              irq_req,
    input logic              vec_byte,
    input logic [VEC_W-1:0]  vec_addr,
    input logic [DATA_W-1:0] ctl_q,
    input logic              fall_seen,
    input logic              edge_pend
);
    assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ctl_q == 8'h10);

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[4] |-> !irq_req);

    assert_disabled_clears_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[4] |=> !edge_pend);

    assert_edge_latched_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[4] && ctl_q[5] && fall_seen) |=> edge_pend);

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        cpu_mask |-> !irq_req);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !fall_seen) |=> !edge_pend);

    assert_vector_R9: assert property (@(posedge clk) disable iff (rst)
        vec_addr == (vec_byte ? 16'h1FFB : 16'h1FFA));
endmodule

bind xirq_ctrl xirq_ctrl_chk chk (
    .clk(clk), .rst(rst), .cpu_mask(cpu_mask), .irq_ack(irq_ack),
    .irq_req(irq_req), .vec_byte(vec_byte), .vec_addr(vec_addr),
    .ctl_q(ctl_q), .fall_seen(fall_seen), .edge_pend(edge_pend)
);

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_pin_n = 1'b1;
    logic        cpu_mask = 1'b0;
    logic        irq_ack = 1'b0;
    logic [7:0]  reg_addr = 8'h0C;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        vec_byte = 1'b0;
    logic [15:0] vec_addr;
    logic        irq_req;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xirq_ctrl uut (
        .clk(clk), .rst(rst), .irq_pin_n(irq_pin_n), .cpu_mask(cpu_mask),
        .irq_ack(irq_ack), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_byte(vec_byte),
        .vec_addr(vec_addr), .irq_req(irq_req)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd_ctl(input logic [7:0] exp, input string req);
        reg_addr = 8'h0C;
        #1;
        check(32'(reg_rdata), 32'(exp), req);
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();

        // R1: reset value and decode of every address
        rd_ctl(8'h10, "R1");
        for (int a = 0; a < 256; a++) begin
            reg_addr = 8'(a);
            #1;
            check(32'(reg_rdata), (a == 12) ? 32'h10 : 32'h0, "R1");
        end
        check(32'(irq_req), 32'h0, "R1");

        // R2: writes elsewhere ignored, all bits of 0x0C stored
        for (int a = 0; a < 256; a++) begin
            if (a != 12) begin
                wr(8'(a), 8'hEF);
                rd_ctl(8'h10, "R2");
            end
        end
        for (int v = 0; v < 256; v += 37) begin
            wr(8'h0C, 8'(v));
            rd_ctl(8'(v), "R2");
        end

        // R9: vector addresses
        vec_byte = 1'b0; #1; check(32'(vec_addr), 32'h1FFA, "R9");
        vec_byte = 1'b1; #1; check(32'(vec_addr), 32'h1FFB, "R9");

        // R4: level latency
        wr(8'h0C, 8'h10);
        irq_pin_n = 1'b0;
        step(); check(32'(irq_req), 32'h0, "R4");
        step(); check(32'(irq_req), 32'h1, "R4");
        irq_pin_n = 1'b1;
        step(); check(32'(irq_req), 32'h1, "R4");
        step(); check(32'(irq_req), 32'h0, "R4");

        // R10: ack ignored in level mode
        irq_pin_n = 1'b0; step(3);
        pulse_ack(); check(32'(irq_req), 32'h1, "R10");
        step(2); check(32'(irq_req), 32'h1, "R10");
        irq_pin_n = 1'b1; step(3);

        // R5: edge latency and hold
        wr(8'h0C, 8'h30);
        irq_pin_n = 1'b0;
        step(2); check(32'(irq_req), 32'h0, "R5");
        step();  check(32'(irq_req), 32'h1, "R5");
        irq_pin_n = 1'b1;
        step(4); check(32'(irq_req), 32'h1, "R5");

        // R7: edge coincident with ack keeps the flag, lone ack clears it
        irq_pin_n = 1'b0;
        step(2);
        pulse_ack();
        check(32'(irq_req), 32'h1, "R7");
        step(2); check(32'(irq_req), 32'h1, "R7");
        pulse_ack();
        check(32'(irq_req), 32'h0, "R7");
        step(2); check(32'(irq_req), 32'h0, "R7");

        // R8: one edge during service is remembered
        irq_pin_n = 1'b1; step(3);
        irq_pin_n = 1'b0; step(4);
        irq_ack = 1'b1; cpu_mask = 1'b1;
        step();
        irq_ack = 1'b0;
        check(32'(irq_req), 32'h0, "R8");
        irq_pin_n = 1'b1; step(3);
        irq_pin_n = 1'b0; step(4);
        check(32'(irq_req), 32'h0, "R8");
        cpu_mask = 1'b0; #1;
        check(32'(irq_req), 32'h1, "R8");
        pulse_ack();
        check(32'(irq_req), 32'h0, "R8");
        irq_pin_n = 1'b1; step(3);

        // R3/R6: sweep of enable, option and mask
        for (int en = 0; en < 2; en++) begin
            for (int op = 0; op < 2; op++) begin
                for (int mk = 0; mk < 2; mk++) begin
                    wr(8'h0C, 8'((op << 5) | (en << 4) | 8'h0A));
                    cpu_mask = mk[0];
                    irq_pin_n = 1'b0; step(4);
                    check(32'(irq_req), 32'((en == 1) && (mk == 0)),
                          (en == 0) ? "R3" : "R6");
                    irq_pin_n = 1'b1; step(4);
                    check(32'(irq_req), 32'((en == 1) && (mk == 0) && (op == 1)),
                          (en == 0) ? "R3" : "R6");
                    cpu_mask = 1'b0; #1;
                    check(32'(irq_req), 32'((en == 1) && (op == 1)), "R6");
                    pulse_ack();
                    check(32'(irq_req), 32'h0, "R7");
                end
            end
        end

        // R3: disabling drops a pending edge
        wr(8'h0C, 8'h30);
        irq_pin_n = 1'b0; step(4);
        check(32'(irq_req), 32'h1, "R5");
        wr(8'h0C, 8'h20);
        check(32'(irq_req), 32'h0, "R3");
        wr(8'h0C, 8'h30);
        step(); check(32'(irq_req), 32'h0, "R3");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule